// File: doc/BRIEF.md
# Fetch-Order Quadrant Pattern Banker

This block sits beside the graphics processor of an 8-bit console and watches its 14-bit video address bus and active-low read strobe. It drives a 15-bit address into a 32 KiB character RAM. That RAM is split into 4 KiB pages, and the page is picked without any register writes.

The graphics processor always fetches in a fixed order. In the background phase, a tile-map byte comes first, then an attribute byte, then the two pattern bytes. In the sprite phase, each group has two discarded tile-map reads and then the two sprite pattern bytes. Because of this order, the block can work out what kind of pattern fetch comes next from the last name-table-region read it saw:

- After an attribute read, the next pattern fetches are background fetches.
- After a tile-map read, the next pattern fetches are sprite fetches.

On every tile-map read, the block stores the column parity and row parity of the tile. When the attribute read that follows arrives, it points the pattern page at one of four background pages. Each corner of a 16x16 metatile therefore has its own 256-tile set, which gives 1024 background tiles in all. Sprites always use a fifth page.

Top module: `chr_quadrant_banker`

## Requirements
- R1: After reset the page register holds 4 and the stored quadrant is 0. A pattern fetch before any name-table-region read maps to page 4.
- R2: A tile-map read sets the page register to 4 from the next clock on. A tile-map read is a strobe fall with A13=1 and A9..A6 not all 1.
- R3: A tile-map read stores the quadrant {A5, A0} of its address: 0 top-left, 1 top-right, 2 bottom-left, 3 bottom-right.
- R4: An attribute read sets the page register to the stored quadrant. An attribute read is a strobe fall with A13=1 and A9..A6 all 1.
- R5: A pattern fetch (A13=0) never changes the page register or the stored quadrant. This holds even when its A9..A6 are all 1.
- R6: The RAM address is {page[2:0], A11..A0}. It follows the bus address combinationally.
- R7: State changes only on a high-to-low transition of the read strobe. An address held with the strobe high, or changed while the strobe stays low, has no effect.
- R8: Decoding ignores A12..A10, so the four 1 KiB table copies at 0x2000, 0x2400, 0x2800, 0x2C00, and their images from 0x3000, behave the same.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, faster than the strobe |
| rst_n | input | 1 | Active-low synchronous reset |
| ppu_addr | input | 14 | Video address bus |
| ppu_rd_n | input | 1 | Active-low read strobe |
| chr_addr | output | 15 | Character RAM address, page in the top 3 bits |

## Verification
A single tile-map strobe edge does two things on the same clock: it overwrites the stored quadrant and it forces the page to 4. The attribute read that follows at once must then use the new quadrant, not the previous one. The bench replays scanlines in which neighbouring tiles differ in parity, so any stale quadrant would show up on the very next background pattern fetch. It also puts tile-map fetches straight after attribute fetches and checks that the next pattern read has left the background page.

// File: rtl/chr_quadrant_banker.sv
module chr_quadrant_banker #(
  parameter int PPU_AW      = 14,
  parameter int PAGE_AW     = 12,
  parameter int BANK_W      = 3,
  parameter int SPRITE_BANK = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PPU_AW-1:0]         ppu_addr,
  input  logic                      ppu_rd_n,
  output logic [BANK_W+PAGE_AW-1:0] chr_addr
);
  localparam int REGION_BIT = PPU_AW - 1;
  localparam int ROW_BIT    = 5;
  localparam int COL_BIT    = 0;
  localparam int ATTR_LO    = 6;
  localparam int ATTR_HI    = 9;
  localparam logic [BANK_W-1:0] SPR_PAGE = BANK_W'(SPRITE_BANK);

  logic              rd_q;
  logic [1:0]        quad_q;
  logic [BANK_W-1:0] bank_q;
  logic              strobe_fall, in_region, attr_hit, tile_hit;
  logic              unused_a12;

  assign unused_a12  = ppu_addr[PAGE_AW];
  assign strobe_fall = rd_q & ~ppu_rd_n;
  assign in_region   = ppu_addr[REGION_BIT];
  assign attr_hit    = in_region &  (&ppu_addr[ATTR_HI:ATTR_LO]);
  assign tile_hit    = in_region & ~(&ppu_addr[ATTR_HI:ATTR_LO]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q   <= 1'b1;
      quad_q <= 2'd0;
      bank_q <= SPR_PAGE;
    end else begin
      rd_q <= ppu_rd_n;
      if (strobe_fall && tile_hit) begin
        quad_q <= {ppu_addr[ROW_BIT], ppu_addr[COL_BIT]};
        bank_q <= SPR_PAGE;
      end else if (strobe_fall && attr_hit) begin
        bank_q <= BANK_W'(quad_q);
      end
    end
  end

  assign chr_addr = {bank_q, ppu_addr[PAGE_AW-1:0]};

  p_tile_sprite_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && tile_hit) |=> (chr_addr[BANK_W+PAGE_AW-1:PAGE_AW] == SPR_PAGE));

  p_quad_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && tile_hit) |=> (quad_q == $past({ppu_addr[ROW_BIT], ppu_addr[COL_BIT]})));

  p_attr_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && attr_hit) |=> (bank_q == BANK_W'($past(quad_q))));

  p_pattern_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_fall && !in_region) |=> ($stable(bank_q) && $stable(quad_q)));

  p_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_fall |=> ($stable(bank_q) && $stable(quad_q)));

  p_page_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q <= SPR_PAGE);
endmodule

// File: tb/sim_chr_quadrant_banker.sv
module sim_chr_quadrant_banker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ppu_addr = 14'h0000;
  logic        ppu_rd_n = 1'b1;
  logic [14:0] chr_addr;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0] exp_bank = 3'd4;
  logic [1:0] exp_quad = 2'd0;

  chr_quadrant_banker u0 (.clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr),
                          .ppu_rd_n(ppu_rd_n), .chr_addr(chr_addr));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [14:0] got, input logic [14:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: chr_addr=%h expected %h", req, got, exp);
    end
  endtask

  task automatic model(input logic [13:0] a);
    if (a[13]) begin
      if (&a[9:6]) exp_bank = {1'b0, exp_quad};
      else begin exp_quad = {a[5], a[0]}; exp_bank = 3'd4; end
    end
  endtask

  task automatic fetch(input logic [13:0] a, output logic [14:0] got);
    ppu_addr = a;
    ppu_rd_n = 1'b0;
    @(negedge clk);
    got = chr_addr;
    ppu_rd_n = 1'b1;
    @(negedge clk);
    model(a);
  endtask

  task automatic fetch_chk(input string req, input logic [13:0] a);
    logic [14:0] got;
    fetch(a, got);
    check(req, got, {exp_bank, a[11:0]});
  endtask

  task automatic t_reset;
    logic [14:0] got;
    fetch(14'h0123, got);
    check("R1", got, {3'd4, 12'h123});
    fetch(14'h1FFF, got);
    check("R1/R6", got, {3'd4, 12'hFFF});
  endtask

  task automatic t_scanline(input logic [13:0] base, input int row);
    for (int col = 0; col < 32; col++) begin
      logic [13:0] nt, at, pat;
      nt  = base + 14'(row * 32 + col);
      at  = base + 14'h3C0 + 14'((row / 4) * 8 + col / 4);
      pat = 14'h1000 | 14'((col * 7 + row) % 256) << 4 | 14'(row % 8);
      fetch_chk("R2 R8", nt);
      fetch_chk("R4 R3 R8", at);
      fetch_chk("R4 R6", pat);
      fetch_chk("R4 R6", pat | 14'h0008);
    end
    for (int s = 0; s < 8; s++) begin
      logic [13:0] pat;
      fetch_chk("R2", base + 14'(s * 3 + 1));
      fetch_chk("R2", base + 14'(s * 33));
      pat = 14'(s * 16 + 5);
      fetch_chk("R2 R6", pat);
      fetch_chk("R2 R6", pat | 14'h0008);
    end
  endtask

  task automatic t_same_edge;
    logic [14:0] got;
    fetch(14'h2021, got); fetch(14'h23C0, got);
    fetch(14'h0040, got);
    check("R3 R4", got, {3'd3, 12'h040});
    fetch(14'h2000, got); fetch(14'h27C1, got);
    fetch(14'h0041, got);
    check("R3 R4", got, {3'd0, 12'h041});
    fetch(14'h2C20, got);
    fetch(14'h0042, got);
    check("R2", got, {3'd4, 12'h042});
    fetch(14'h2BFF, got);
    fetch(14'h0043, got);
    check("R4 R8", got, {3'd2, 12'h043});
    exp_bank = 3'd2; exp_quad = 2'd2;
  endtask

  task automatic t_pattern_hold;
    logic [14:0] got;
    fetch(14'h2001, got); fetch(14'h23C1, got);
    for (int i = 0; i < 4; i++) begin
      fetch(14'h03C0 | 14'(i), got);
      check("R5", got, {3'd1, 12'h3C0 | 12'(i)});
    end
    fetch(14'h13FF, got);
    check("R5", got, {3'd1, 12'h3FF});
    exp_bank = 3'd1; exp_quad = 2'd1;
  endtask

  task automatic t_strobe;
    logic [14:0] got;
    ppu_addr = 14'h2021;
    repeat (3) @(negedge clk);
    check("R7", chr_addr, {3'd1, 12'h021});
    ppu_addr = 14'h23C2;
    repeat (2) @(negedge clk);
    ppu_addr = 14'h0100;
    @(negedge clk);
    check("R7", chr_addr, {3'd1, 12'h100});
    ppu_addr = 14'h23C0;
    ppu_rd_n = 1'b0;
    @(negedge clk);
    ppu_addr = 14'h2000;
    repeat (3) @(negedge clk);
    check("R7", chr_addr, {3'd1, 12'h000});
    ppu_rd_n = 1'b1;
    @(negedge clk);
    fetch(14'h0200, got);
    check("R7", got, {3'd1, 12'h200});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scanline(14'h2000, 0);
    t_scanline(14'h2400, 1);
    t_scanline(14'h2800, 6);
    t_scanline(14'h2C00, 13);
    t_scanline(14'h3000, 29);
    t_same_edge();
    t_pattern_hold();
    t_strobe();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule